// File: doc/BRIEF.md
# Dual-Bus Manchester Word Transmitter

This block turns a 16-bit host word into a serial Manchester II word for a dual-redundant 1 Mbit/s avionics data bus. Each load pulse carries the data, a sync-type bit and a bus select. The word is sent as 20 bit periods: a three-period sync, the 16 data bits with the most significant bit first, and an odd parity bit that the block computes itself. The output appears on one of two buses. Each bus is a pair of complementary drive enables, positive and negative, that would control an external line driver.

Bit timing comes from a free-running divider on the 12 MHz clock. One bit period is 12 clocks, split into two halves of 6 clocks. A load that arrives while the transmitter is idle is held until the next bit-period boundary and then starts. A load that arrives while a word is in progress waits in a holding register and follows the current word with no gap. A ready flag marks the window from 3.5 us to 18.5 us after a word starts; a load inside that window is a safe contiguous follow-on. For three or more words, the host spaces its loads 20 us apart.

Each bus has a disable input that keeps its outputs idle. Loads, timing and the ready flag are unaffected by it.

Top module: `mbus_word_tx`

## Requirements
- R1: After reset both outputs of both buses are 0 and `ready_o` is 1. Both outputs of both buses are 0 whenever no word is being sent.
- R2: A bit period lasts exactly 12 clocks and each half lasts 6 clocks. A single word keeps its bus active for exactly 240 consecutive clocks.
- R3: With `ld_cmd_i`=1 (command sync), the positive output is high for the first 18 clocks of the word and the negative output for the next 18 clocks. With `ld_cmd_i`=0 (data sync) the order is reversed.
- R4: Data bits follow the sync with bit 15 first. A 1 is sent as positive-high for 6 clocks then negative-high for 6 clocks. A 0 is sent as negative-high then positive-high. While a word is sent on an enabled bus, exactly one of its two outputs is high.
- R5: The last bit period carries a parity bit. It makes the count of ones over the 16 data bits plus parity odd, and it is encoded like a data bit.
- R6: A divider that runs freely from reset release defines bit boundaries every 12 clocks. A load into an idle transmitter starts the word at the clock after the next boundary, which is the first clock whose divider count is 0.
- R7: `ready_o` is 1 while idle with an empty holding register. It is 0 from the clock after a load into an idle transmitter. During a word it is 1 exactly from clock 42 to clock 221 of the word (3.5 us to 18.5 us), counting from clock 0 at word start.
- R8: A word loaded while another is being sent starts on the clock right after the last clock of the current word, with no idle cycle. Three words loaded 20 us apart keep the bus active for 720 consecutive clocks.
- R9: `ld_bus_i`=0 selects bus index 0 and 1 selects bus index 1. The unselected bus stays idle.
- R10: While `tx_dis_i[b]`=1, both outputs of bus b are 0. The disable takes effect in the same clock. Loads are still accepted, the ready flag still follows R7, and the other bus is unaffected.
- R11: A second load before the holding register has moved to the shift register replaces the first. Only the last loaded word is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 12 MHz system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_i | input | 1 | One-clock load pulse for the holding register |
| ld_data_i | input | 16 | Word to send |
| ld_cmd_i | input | 1 | Sync type: 1 command/status, 0 data |
| ld_bus_i | input | 1 | Bus select: 0 bus index 0, 1 bus index 1 |
| tx_dis_i | input | 2 | Per-bus transmit disable |
| tx_pos_o | output | 2 | Positive drive enable, one per bus |
| tx_neg_o | output | 2 | Negative drive enable, one per bus |
| ready_o | output | 1 | Contiguous-load window / idle-empty flag |

## Verification
The line outputs and the ready flag are decoded from registers only. A load sampled at a clock edge therefore shows on `ready_o` in the next cycle, and on the line at the first clock after the next 12-clock boundary, or right after the current word ends. Disables act on the line in the same cycle. The bench drives inputs 1 ns after the rising edge and keeps its own model, built from word start times and elapsed clock counts. It compares that model with every output at each falling edge, so each result is checked in the cycle it is due. Run-length counters add checks on word length, back-to-back chaining, bus choice and overwrite.

// File: rtl/mbt_pkg.sv
`timescale 1ns/1ps
package mbt_pkg;
    localparam int NUM_BUS = 2;
    localparam int SEL_W   = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;

    typedef enum logic {
        SYNC_DATA = 1'b0,
        SYNC_CMD  = 1'b1
    } sync_e;
endpackage

// File: rtl/mbt_bit_timer.sv
`timescale 1ns/1ps
module mbt_bit_timer #(
    parameter int HALF_CLKS = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic half_end_o,
    output logic bit_end_o
);
    localparam int BIT_CLKS = 2 * HALF_CLKS;
    localparam int CNT_W    = $clog2(BIT_CLKS);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_CLKS - 1);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(BIT_CLKS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == BIT_LAST) ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign bit_end_o  = (cnt_q == BIT_LAST);
    assign half_end_o = (cnt_q == HALF_LAST) || bit_end_o;

    // R2
    half_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        half_end_o |=> !half_end_o);
endmodule

// File: rtl/mbt_line_drive.sv
`timescale 1ns/1ps
module mbt_line_drive
    import mbt_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               active_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               level_i,
    input  logic [NUM_BUS-1:0] dis_i,
    output logic [NUM_BUS-1:0] pos_o,
    output logic [NUM_BUS-1:0] neg_o
);
    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        logic drive;
        assign drive    = active_i && (sel_i == SEL_W'(b)) && !dis_i[b];
        assign pos_o[b] = drive && level_i;
        assign neg_o[b] = drive && !level_i;
    end

    // R9
    one_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(pos_o | neg_o));
    // R4
    pair_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pos_o & neg_o) == '0);
endmodule

// File: rtl/mbus_word_tx.sv
`timescale 1ns/1ps
module mbus_word_tx
    import mbt_pkg::*;
#(
    parameter int DATA_W         = 16,
    parameter int HALF_CLKS      = 6,
    parameter int SYNC_HALVES    = 6,
    parameter int READY_ON_HALF  = 7,
    parameter int READY_OFF_HALF = 37
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               ld_i,
    input  logic [DATA_W-1:0]  ld_data_i,
    input  logic               ld_cmd_i,
    input  logic               ld_bus_i,
    input  logic [NUM_BUS-1:0] tx_dis_i,
    output logic [NUM_BUS-1:0] tx_pos_o,
    output logic [NUM_BUS-1:0] tx_neg_o,
    output logic               ready_o
);
    localparam int WORD_HALVES = SYNC_HALVES + 2 * (DATA_W + 1);
    localparam int SLOT_W      = $clog2(WORD_HALVES);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WORD_HALVES - 1);
    localparam logic [SLOT_W-1:0] SYNC_LAST = SLOT_W'(SYNC_HALVES - 1);
    localparam logic [SLOT_W-1:0] SYNC_MID  = SLOT_W'(SYNC_HALVES / 2);
    localparam logic [SLOT_W-1:0] RDY_ON    = SLOT_W'(READY_ON_HALF);
    localparam logic [SLOT_W-1:0] RDY_OFF   = SLOT_W'(READY_OFF_HALF);

    typedef struct packed {
        logic              active;
        logic [SLOT_W-1:0] slot;
        logic [DATA_W:0]   shreg;
        sync_e             sync;
        logic [SEL_W-1:0]  bus;
        logic              hold_vld;
        logic [DATA_W-1:0] hold_data;
        sync_e             hold_sync;
        logic [SEL_W-1:0]  hold_bus;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      half_end, bit_end;
    logic      start_word;
    logic      level;

    mbt_bit_timer #(.HALF_CLKS(HALF_CLKS)) i_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .half_end_o (half_end),
        .bit_end_o  (bit_end)
    );

    always_comb begin
        st_d       = st_q;
        start_word = 1'b0;
        if (st_q.active) begin
            if (half_end) begin
                if (st_q.slot == LAST_SLOT) begin
                    if (st_q.hold_vld) start_word = 1'b1;
                    else               st_d.active = 1'b0;
                end else begin
                    st_d.slot = st_q.slot + SLOT_W'(1);
                    if (st_q.slot[0] && (st_q.slot > SYNC_LAST)) begin
                        st_d.shreg = {st_q.shreg[DATA_W-1:0], 1'b0};
                    end
                end
            end
        end else if (bit_end && st_q.hold_vld) begin
            start_word = 1'b1;
        end

        if (start_word) begin
            st_d.active   = 1'b1;
            st_d.slot     = '0;
            st_d.shreg    = {st_q.hold_data, ~^st_q.hold_data};
            st_d.sync     = st_q.hold_sync;
            st_d.bus      = st_q.hold_bus;
            st_d.hold_vld = 1'b0;
        end

        if (ld_i) begin
            st_d.hold_vld  = 1'b1;
            st_d.hold_data = ld_data_i;
            st_d.hold_sync = sync_e'(ld_cmd_i);
            st_d.hold_bus  = SEL_W'(ld_bus_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q           <= '0;
            st_q.sync      <= SYNC_DATA;
            st_q.hold_sync <= SYNC_DATA;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.slot <= SYNC_LAST) begin
            level = (st_q.sync == SYNC_CMD) ? (st_q.slot < SYNC_MID)
                                            : (st_q.slot >= SYNC_MID);
        end else begin
            level = st_q.slot[0] ? ~st_q.shreg[DATA_W] : st_q.shreg[DATA_W];
        end
    end

    assign ready_o = st_q.active ? ((st_q.slot >= RDY_ON) && (st_q.slot < RDY_OFF))
                                 : !st_q.hold_vld;

    mbt_line_drive i_drive (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .active_i (st_q.active),
        .sel_i    (st_q.bus),
        .level_i  (level),
        .dis_i    (tx_dis_i),
        .pos_o    (tx_pos_o),
        .neg_o    (tx_neg_o)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.active |-> (tx_pos_o == '0 && tx_neg_o == '0));
    // R2
    slot_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.active && half_end && st_q.slot != LAST_SLOT)
            |=> (st_q.slot == $past(st_q.slot) + SLOT_W'(1)));
    // R6
    idle_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.active && !bit_end) |=> !st_q.active);
    // R7
    ready_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.active && st_q.hold_vld) |-> !ready_o);
    // R8
    back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.active && half_end && st_q.slot == LAST_SLOT && st_q.hold_vld)
            |=> (st_q.active && st_q.slot == '0));
    // R10
    dis_quiet_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_dis_i[0] |-> (!tx_pos_o[0] && !tx_neg_o[0]));
    // R10
    dis_quiet_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_dis_i[1] |-> (!tx_pos_o[1] && !tx_neg_o[1]));
endmodule

// File: tb/test_mbus_word_tx.sv
`timescale 1ns/1ps
module test_mbus_word_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld = 1'b0;
    logic [15:0] ld_data = '0;
    logic        ld_cmd = 1'b0;
    logic        ld_bus = 1'b0;
    logic [1:0]  dis = '0;
    logic [1:0]  pos, neg;
    logic        ready;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mbus_word_tx i_mbus_word_tx (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .ld_i      (ld),
        .ld_data_i (ld_data),
        .ld_cmd_i  (ld_cmd),
        .ld_bus_i  (ld_bus),
        .tx_dis_i  (dis),
        .tx_pos_o  (pos),
        .tx_neg_o  (neg),
        .ready_o   (ready)
    );

    // Behavioural reference: word timeline in clocks since start.
    bit        m_busy, m_pend, m_cmd, m_pcmd, m_bus, m_pbus;
    int        m_t, m_ph;
    bit [15:0] m_data, m_pdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_pend = 0; m_t = 0; m_ph = 0;
        end else begin
            if (m_busy) begin
                if (m_t == 239) begin
                    if (m_pend) begin
                        m_t = 0; m_data = m_pdata; m_cmd = m_pcmd; m_bus = m_pbus; m_pend = 0;
                    end else begin
                        m_busy = 0;
                    end
                end else begin
                    m_t = m_t + 1;
                end
            end else if (m_ph == 11 && m_pend) begin
                m_busy = 1; m_t = 0; m_data = m_pdata; m_cmd = m_pcmd; m_bus = m_pbus; m_pend = 0;
            end
            if (ld) begin
                m_pend = 1; m_pdata = ld_data; m_pcmd = ld_cmd; m_pbus = ld_bus;
            end
            m_ph = (m_ph + 1) % 12;
        end
    end

    function automatic bit exp_level(int t, bit cmd, bit [15:0] d);
        int h = t / 6;
        bit b;
        if (h < 6) return cmd ? (h < 3) : (h >= 3);
        if (h < 38) b = d[15 - (h - 6) / 2];
        else        b = ~^d;
        return (h % 2 == 0) ? b : !b;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Run-length monitor per bus.
    int run [2];
    int last_run [2];
    int tot [2];

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit [1:0] ep, en;
            bit       er, lv;
            string    tag;
            int       h;
            ep = '0; en = '0;
            h = m_t / 6;
            if (m_busy) begin
                lv = exp_level(m_t, m_cmd, m_data);
                if (!dis[m_bus]) begin
                    ep[m_bus] = lv; en[m_bus] = !lv;
                end
                er = (h >= 7 && h < 37);
            end else begin
                er = !m_pend;
            end
            if (!m_busy)              tag = "R6/R1";
            else if (dis[m_bus])      tag = "R10";
            else if (h < 6)           tag = "R3";
            else if (h < 38)          tag = "R4";
            else                      tag = "R5";
            check(tag, {pos, neg}, {ep, en});
            check("R7", ready, er);
            for (int b = 0; b < 2; b++) begin
                if (pos[b] | neg[b]) begin
                    run[b]++; tot[b]++;
                end else if (run[b] > 0) begin
                    last_run[b] = run[b]; run[b] = 0;
                end
            end
        end
    end

    task automatic load(bit [15:0] d, bit c, bit b);
        @(posedge clk); #1;
        ld = 1; ld_data = d; ld_cmd = c; ld_bus = b;
        @(posedge clk); #1;
        ld = 0;
    endtask

    task automatic wait_ready_window();
        while (ready) @(negedge clk);
        while (!ready) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        int t0;
        run = '{0, 0}; last_run = '{0, 0}; tot = '{0, 0};
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1", {pos, neg}, 0);
        check("R1", ready, 1);

        // R2 / R3: single command-sync word on bus 0
        load(16'hA5C3, 1, 0);
        @(negedge clk);
        check("R7", ready, 0);
        repeat (280) @(posedge clk);
        check("R2", last_run[0], 240);
        check("R9", tot[1], 0);

        // R9 / R5: data-sync word of zeros on bus 1 (parity 1)
        load(16'h0000, 0, 1);
        repeat (280) @(posedge clk);
        check("R9", last_run[1], 240);

        // R8: two contiguous words
        load(16'h1234, 0, 0);
        wait_ready_window();
        load(16'hFFFF, 1, 0);
        repeat (520) @(posedge clk);
        check("R8", last_run[0], 480);

        // R8: three words spaced 20 us
        load(16'h0001, 1, 0);
        wait_ready_window();
        load(16'h8000, 0, 0);
        repeat (239) @(posedge clk);
        load(16'h7FFE, 1, 0);
        repeat (760) @(posedge clk);
        check("R8", last_run[0], 720);

        // R11: overwrite of the holding register
        load(16'h1111, 0, 1);
        wait_ready_window();
        load(16'h2222, 1, 1);
        load(16'h3333, 0, 1);
        repeat (520) @(posedge clk);
        check("R11", last_run[1], 480);

        // R10: disabled bus stays quiet, load still accepted
        @(posedge clk); #1 dis = 2'b01;
        t0 = tot[0];
        load(16'hBEEF, 1, 0);
        @(negedge clk);
        check("R10", ready, 0);
        repeat (280) @(posedge clk);
        check("R10", tot[0], t0);
        check("R10", ready, 1);
        load(16'hC0DE, 0, 1);
        repeat (280) @(posedge clk);
        check("R10", last_run[1], 240);

        // R10: disable applied mid-word
        @(posedge clk); #1 dis = 2'b00;
        load(16'h5A5A, 1, 1);
        repeat (100) @(posedge clk);
        #1 dis = 2'b10;
        repeat (60) @(posedge clk);
        #1 dis = 2'b00;
        repeat (200) @(posedge clk);
        check("R10", run[1], 0);

        finish_run();
    end
endmodule